// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Device

This block is one output cell of a small programmable sum-of-products device. It receives the product terms that the AND array produces for this cell. It ORs them and can invert the sum. It then either registers the result or passes it through combinationally. The block drives the pin value, the pin's tri-state enable and a feedback bit that returns to the AND array.

Two device-wide configuration bits choose whether the device has registers. A per-cell I/O bit then chooses the behaviour of this cell. A per-cell polarity bit inverts the sum. The most significant product term either joins the OR or becomes the cell's own output enable. Feedback comes from the register, from the driven output, from the pin, or is tied low. A parameter marks cells that have no feedback path.

Top module: `pal_macrocell`

## Requirements
- R1: Registered cell (cfg_glb=2'b10, cfg_io=0). On each rising clk edge the register loads the OR of all NUM_PT product terms. fb_out shows the true register output Q, before any inversion. pin_oe follows glb_oe.
- R2: cfg_inv=1 inverts the sum on its way to pin_out, and cfg_inv=0 passes it unchanged. In registered mode pin_out equals Q XOR cfg_inv.
- R3: When rst_n is low the register clears to 0 asynchronously. A registered cell then shows fb_out=0 and pin_out=cfg_inv.
- R4: Dedicated combinatorial output (cfg_glb=2'b01, cfg_io=0). pin_out is the OR of all NUM_PT terms, XOR cfg_inv, within the same cycle. pin_oe=1, and fb_out equals the value driven on pin_out.
- R5: With the parameter NO_FB=1, a dedicated-output cell drives fb_out to 0.
- R6: Combinatorial I/O in a device without registers (cfg_glb=2'b11, cfg_io=1). pin_out is the OR of pterm[NUM_PT-2:0], XOR cfg_inv. pin_oe equals pterm[NUM_PT-1], and fb_out equals pin_in.
- R7: Combinatorial I/O in a device with registers (cfg_glb=2'b10, cfg_io=1) behaves as in R6.
- R8: Dedicated input (cfg_glb=2'b01, cfg_io=1). pin_oe=0, pin_out=0 and fb_out=pin_in.
- R9: Every other code (cfg_glb=2'b00 with any cfg_io, or cfg_glb=2'b11 with cfg_io=0) gives pin_oe=0, pin_out=0 and fb_out=pin_in.
- R10: The register loads only while the cell is in registered mode. In any other mode it keeps its value, and the kept value reappears on fb_out as soon as registered mode is selected again.
- R11: glb_oe has no effect on any output outside registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the register |
| pterm | input | NUM_PT | Product terms from the AND array |
| glb_oe | input | 1 | Device-wide output enable for registered cells |
| cfg_glb | input | 2 | Device-wide mode bits |
| cfg_io | input | 1 | Per-cell I/O select bit |
| cfg_inv | input | 1 | Per-cell output inversion bit |
| pin_in | input | 1 | Level sensed at the pin |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Tri-state enable of the pin driver |
| fb_out | output | 1 | Feedback bit to the AND array |

## Verification
Single-hot product-term patterns separate the seven-term OR from the eight-term OR. A pattern with only the top term set shows whether that term feeds the sum or the enable. Each pattern runs with both polarity settings, so inversion errors and register-versus-pin feedback errors show up separately. A mode switch after the register has been loaded shows whether the register holds, and a reset in the middle of a run checks the clear. Long random runs over all eight configuration codes, compared against a reference model on every cycle, also toggle glb_oe and pin_in, so any leak of those inputs into the wrong mode is visible. A second instance with feedback removed is checked in the same runs.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [2:0] {
    CM_REG      = 3'd0,
    CM_IO_REGD  = 3'd1,
    CM_DED_OUT  = 3'd2,
    CM_IO_NOREG = 3'd3,
    CM_DED_IN   = 3'd4,
    CM_OFF      = 3'd5
  } cell_mode_e;

  localparam logic [1:0] GLB_REGDEV  = 2'b10;
  localparam logic [1:0] GLB_SIMPLE  = 2'b01;
  localparam logic [1:0] GLB_COMBIO  = 2'b11;
endpackage

// File: rtl/mcell_decode.sv
module mcell_decode
  import mcell_pkg::*;
(
  input  logic [1:0] cfg_glb,
  input  logic       cfg_io,
  output cell_mode_e mode
);
  always_comb begin
    mode = CM_OFF;
    unique case (cfg_glb)
      GLB_REGDEV: mode = cfg_io ? CM_IO_REGD : CM_REG;
      GLB_SIMPLE: mode = cfg_io ? CM_DED_IN  : CM_DED_OUT;
      GLB_COMBIO: mode = cfg_io ? CM_IO_NOREG : CM_OFF;
      default:    mode = CM_OFF;
    endcase
  end
endmodule

// File: rtl/mcell_sum.sv
module mcell_sum #(
  parameter int unsigned NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pterm,
  output logic              sum_all,
  output logic              sum_low,
  output logic              top_term
);
  localparam int unsigned LOW_W = (NUM_PT > 1) ? NUM_PT - 1 : 1;

  logic [NUM_PT-1:0] chain;

  generate
    for (genvar i = 0; i < NUM_PT; i++) begin : g_or
      if (i == 0) begin : g_first
        assign chain[i] = pterm[i];
      end else begin : g_next
        assign chain[i] = chain[i-1] | pterm[i];
      end
    end
    if (NUM_PT > 1) begin : g_split
      assign sum_low = chain[LOW_W-1];
    end else begin : g_single
      assign sum_low = 1'b0;
    end
  endgenerate

  assign sum_all  = chain[NUM_PT-1];
  assign top_term = pterm[NUM_PT-1];
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_en,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import mcell_pkg::*;
#(
  parameter int unsigned NUM_PT = 8,
  parameter bit          NO_FB  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PT-1:0] pterm,
  input  logic              glb_oe,
  input  logic [1:0]        cfg_glb,
  input  logic              cfg_io,
  input  logic              cfg_inv,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              fb_out
);
  cell_mode_e mode;
  logic sum_all, sum_low, top_term;
  logic reg_q, reg_ld;

  mcell_decode u_dec (
    .cfg_glb (cfg_glb),
    .cfg_io  (cfg_io),
    .mode    (mode)
  );

  mcell_sum #(.NUM_PT(NUM_PT)) u_sum (
    .pterm    (pterm),
    .sum_all  (sum_all),
    .sum_low  (sum_low),
    .top_term (top_term)
  );

  assign reg_ld = (mode == CM_REG);

  mcell_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_en (reg_ld),
    .d     (sum_all),
    .q     (reg_q)
  );

  always_comb begin
    pin_out = 1'b0;
    pin_oe  = 1'b0;
    fb_out  = pin_in;
    unique case (mode)
      CM_REG: begin
        pin_out = reg_q ^ cfg_inv;
        pin_oe  = glb_oe;
        fb_out  = reg_q;
      end
      CM_IO_REGD, CM_IO_NOREG: begin
        pin_out = sum_low ^ cfg_inv;
        pin_oe  = top_term;
        fb_out  = pin_in;
      end
      CM_DED_OUT: begin
        pin_out = sum_all ^ cfg_inv;
        pin_oe  = 1'b1;
        fb_out  = NO_FB ? 1'b0 : (sum_all ^ cfg_inv);
      end
      default: begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        fb_out  = pin_in;
      end
    endcase
  end
endmodule

// File: rtl/mcell_chk.sv
module mcell_chk #(
  parameter int unsigned NUM_PT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_PT-1:0] pterm,
  input logic              glb_oe,
  input logic [1:0]        cfg_glb,
  input logic              cfg_io,
  input logic              cfg_inv,
  input logic              pin_in,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              fb_out
);
  logic reg_cfg, io_cfg, in_cfg, off_cfg;
  assign reg_cfg = (cfg_glb == 2'b10) && !cfg_io;
  assign io_cfg  = (cfg_glb == 2'b10 || cfg_glb == 2'b11) && cfg_io;
  assign in_cfg  = (cfg_glb == 2'b01) && cfg_io;
  assign off_cfg = (cfg_glb == 2'b00) || ((cfg_glb == 2'b11) && !cfg_io);

  a_r1_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cfg |=> (!reg_cfg || fb_out == $past(|pterm)));

  a_r1_global_oe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cfg |-> (pin_oe == glb_oe));

  a_r2_reg_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cfg |-> (pin_out == (fb_out ^ cfg_inv)));

  a_r6_io_enable: assert property (@(posedge clk) disable iff (!rst_n)
    io_cfg |-> (pin_oe == pterm[NUM_PT-1] && fb_out == pin_in));

  a_r8_input_only: assert property (@(posedge clk) disable iff (!rst_n)
    in_cfg |-> (!pin_oe && fb_out == pin_in));

  a_r9_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    off_cfg |-> (!pin_oe && !pin_out && fb_out == pin_in));
endmodule

bind pal_macrocell mcell_chk #(.NUM_PT(NUM_PT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pterm   (pterm),
  .glb_oe  (glb_oe),
  .cfg_glb (cfg_glb),
  .cfg_io  (cfg_io),
  .cfg_inv (cfg_inv),
  .pin_in  (pin_in),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .fb_out  (fb_out)
);

// File: tb/test_pal_macrocell.sv
module test_pal_macrocell;
  localparam int NPT = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NPT-1:0] pterm;
  logic           glb_oe, cfg_io, cfg_inv, pin_in;
  logic [1:0]     cfg_glb;
  logic           a_out, a_oe, a_fb;
  logic           b_out, b_oe, b_fb;

  int checks = 0;
  int errors = 0;
  bit model_q;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pal_macrocell #(.NUM_PT(NPT), .NO_FB(1'b0)) i_pal_macrocell (
    .clk(clk), .rst_n(rst_n), .pterm(pterm), .glb_oe(glb_oe),
    .cfg_glb(cfg_glb), .cfg_io(cfg_io), .cfg_inv(cfg_inv), .pin_in(pin_in),
    .pin_out(a_out), .pin_oe(a_oe), .fb_out(a_fb));

  pal_macrocell #(.NUM_PT(NPT), .NO_FB(1'b1)) i_pal_macrocell_nofb (
    .clk(clk), .rst_n(rst_n), .pterm(pterm), .glb_oe(glb_oe),
    .cfg_glb(cfg_glb), .cfg_io(cfg_io), .cfg_inv(cfg_inv), .pin_in(pin_in),
    .pin_out(b_out), .pin_oe(b_oe), .fb_out(b_fb));

  // reference register: loads only in registered mode
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_q <= 1'b0;
    else if (cfg_glb == 2'b10 && !cfg_io) model_q <= |pterm;
  end

  function automatic string tag_of();
    if (cfg_glb == 2'b10 && !cfg_io) return "R1/R2";
    if (cfg_glb == 2'b10 && cfg_io)  return "R7/R2";
    if (cfg_glb == 2'b11 && cfg_io)  return "R6/R2";
    if (cfg_glb == 2'b01 && !cfg_io) return "R4/R5/R11";
    if (cfg_glb == 2'b01 && cfg_io)  return "R8/R11";
    return "R9/R11";
  endfunction

  task automatic expect_vals(input bit nofb, output bit eo, output bit eoe, output bit efb);
    bit s8, s7;
    s8 = |pterm;
    s7 = |pterm[NPT-2:0];
    if (cfg_glb == 2'b10 && !cfg_io) begin
      eo = model_q ^ cfg_inv; eoe = glb_oe; efb = model_q;
    end else if ((cfg_glb == 2'b10 || cfg_glb == 2'b11) && cfg_io) begin
      eo = s7 ^ cfg_inv; eoe = pterm[NPT-1]; efb = pin_in;
    end else if (cfg_glb == 2'b01 && !cfg_io) begin
      eo = s8 ^ cfg_inv; eoe = 1'b1; efb = nofb ? 1'b0 : eo;
    end else begin
      eo = 1'b0; eoe = 1'b0; efb = pin_in;
    end
  endtask

  task automatic cmp(input string tag, input string nm, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%0b exp=%0b cfg=%b io=%b inv=%b pt=%h", tag, nm, got, exp,
               cfg_glb, cfg_io, cfg_inv, pterm);
    end
  endtask

  task automatic check_now(input string extra);
    bit eo, eoe, efb;
    string t;
    t = {tag_of(), extra};
    expect_vals(1'b0, eo, eoe, efb);
    cmp(t, "out", a_out, eo);
    cmp(t, "oe",  a_oe,  eoe);
    cmp(t, "fb",  a_fb,  efb);
    expect_vals(1'b1, eo, eoe, efb);
    cmp(t, "nofb.out", b_out, eo);
    cmp(t, "nofb.oe",  b_oe,  eoe);
    cmp(t, "nofb.fb",  b_fb,  efb);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
    check_now("");
  endtask

  task automatic setcfg(input logic [1:0] g, input logic io, input logic inv);
    cfg_glb = g; cfg_io = io; cfg_inv = inv;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pterm = '0; glb_oe = 1'b1; pin_in = 1'b0;
    setcfg(2'b10, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    #1;
    // R3: reset state of a registered cell
    cmp("R3", "fb reset", a_fb, 1'b0);
    cmp("R3", "out reset", a_out, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed sweep: every code, both polarities, single-hot and edge patterns
    for (int code = 0; code < 8; code++) begin
      for (int inv = 0; inv < 2; inv++) begin
        setcfg(code[2:1], code[0], inv[0]);
        pterm = '0; pin_in = 1'b1; glb_oe = 1'b0;
        tick();
        for (int b = 0; b < NPT; b++) begin
          pterm = NPT'(1) << b;
          pin_in = b[0];
          glb_oe = b[1];
          tick();
        end
        pterm = '1; tick();
        pterm = '0; tick();
      end
    end

    // R10: register holds while another mode is selected
    setcfg(2'b10, 1'b0, 1'b0);
    pterm = '1; glb_oe = 1'b1;
    tick();
    setcfg(2'b01, 1'b1, 1'b0);
    pterm = '0;
    repeat (4) tick();
    setcfg(2'b11, 1'b1, 1'b0);
    repeat (3) tick();
    setcfg(2'b10, 1'b0, 1'b0);
    #1;
    cmp("R10", "held fb", a_fb, 1'b1);
    cmp("R10", "held out", a_out, 1'b1);
    tick();
    cmp("R10", "reload fb", a_fb, 1'b0);

    // R11: glb_oe toggling in dedicated output mode
    setcfg(2'b01, 1'b0, 1'b0);
    pterm = 8'h00; glb_oe = 1'b0; #1;
    cmp("R11", "oe glb_oe=0", a_oe, 1'b1);
    glb_oe = 1'b1; #1;
    cmp("R11", "oe glb_oe=1", a_oe, 1'b1);
    cmp("R5", "nofb fb", b_fb, 1'b0);

    // random run with a mid-run reset
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      pterm  = (r[31:30] == 2'b00) ? '0 : NPT'(r[NPT-1:0] & r[15:8]);
      glb_oe = r[16];
      pin_in = r[17];
      if (r[21:18] < 3) setcfg(r[24:23], r[25], r[26]);
      if (n == 2000) begin
        setcfg(2'b10, 1'b0, 1'b0);
        pterm = '1;
        tick();
        rst_n = 1'b0;
        #1;
        cmp("R3", "fb mid reset", a_fb, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
      end
      tick();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule